// File: doc/BRIEF.md
# Glitch-Free System Clock Selector

This block picks the clock that drives a chip's core and peripheral logic from one of two free-running sources: a crystal oscillator clock and a phase-locked loop clock. A select bit chooses the loop clock when high and the oscillator clock when low. A self-clock-mode flag forces the loop clock whatever the select bit says. The chosen clock leaves the block as the core clock. A bus clock at half that rate is derived from it.

A change of source never produces a runt pulse. The current source's gate is first closed through a synchronizer clocked by that source. Only after that is the new source's gate opened through a synchronizer clocked by the new source. Both gates open and close only while their own clock is low. Between the two steps the core and bus clocks are frozen, and a busy status is raised. A request that arrives during a switch waits until the switch in progress has finished.

The block also drives the enable of the loop circuit. An off request is overridden whenever the loop clock is requested, pending or in use.

Top module: `sysclk_selector`

## Requirements
- R1: With `pll_sel_i` = 1 and the switch finished, `core_clk_o` runs at the loop clock period. With `pll_sel_i` = 0 and `scm_i` = 0, it runs at the oscillator period.
- R2: The two source gates are never open at the same time. No high or low phase of `core_clk_o` or `bus_clk_o` is shorter than the shorter source half-period.
- R3: After any change of the effective request, `busy_o` returns low within 4 oscillator periods plus 4 loop clock periods.
- R4: `busy_o` goes high as soon as the effective request differs from the active source. While both gates are closed, `busy_o` is high and `core_clk_o` and `bus_clk_o` have no edges. This gives a low phase longer than one oscillator period during each switch.
- R5: With `scm_i` = 1, the loop clock is selected even when `pll_sel_i` = 0. The internal target only moves to a source that the request inputs asked for in the previous oscillator cycle.
- R6: `bus_clk_o` toggles on every rising edge of `core_clk_o`, so its period is twice the core period.
- R7: `pll_en_o` is high whenever the loop clock is requested, pending or gated onto the core clock, regardless of `pll_on_req_i`. Once the oscillator is fully selected, `pll_en_o` follows `pll_on_req_i` within two oscillator cycles.
- R8: While `rst` is high, the oscillator is selected, `bus_clk_o` is low and `pll_en_o` is low. After release with no request, `busy_o` is low.
- R9: A request change that arrives while a switch is in progress is taken up only after that switch ends. `busy_o` then stays high without a gap until the final source is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running oscillator clock; also clocks the control logic |
| pll_clk | input | 1 | Free-running loop clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| pll_sel_i | input | 1 | Source select: 1 picks the loop clock, 0 the oscillator clock |
| scm_i | input | 1 | Self-clock-mode flag; forces the loop clock |
| pll_on_req_i | input | 1 | Software request to run the loop circuit |
| core_clk_o | output | 1 | Gated system clock driving the core |
| bus_clk_o | output | 1 | System clock divided by two |
| pll_en_o | output | 1 | Enable for the loop circuit |
| busy_o | output | 1 | High while a source change is pending or in progress |

## Verification
The assertions are checked on every cycle. They cover: the two gates never being open together; busy being high whenever both gates are closed; the loop enable being high whenever the loop gate is open; the target changing only toward what the request inputs asked for; and the divider toggling on every core edge. Only the bench's scenarios can show the properties that are measured in time across both clock domains. These are the 4+4 cycle bound on a switch, the minimum phase width on both outputs, the length of the frozen interval, and the deferral of a request that arrives mid-switch.

// File: rtl/sysclk_sel_pkg.sv
package sysclk_sel_pkg;

  // default synchronizer depth on each side of the handshake
  localparam int unsigned SYNC_STAGES_DEF = 2;

  // true when the gate pair matches the wanted source
  function automatic logic src_settled(input logic want_pll,
                                       input logic osc_on,
                                       input logic pll_on);
    return want_pll ? (pll_on && !osc_on) : (osc_on && !pll_on);
  endfunction

endpackage

// File: rtl/sysclk_bit_sync.sv
module sysclk_bit_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) begin
      ff <= {STAGES{RST_VAL}};
    end else begin
      ff[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        ff[i] <= ff[i-1];
      end
    end
  end

  assign q = ff[STAGES-1];

endmodule

// File: rtl/sysclk_gate_leg.sv
module sysclk_gate_leg #(
  parameter int unsigned STAGES = 2,
  parameter bit          RST_ON = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic want,
  output logic gate_on
);

  logic want_sync;

  sysclk_bit_sync #(
    .STAGES  (STAGES),
    .RST_VAL (RST_ON)
  ) want_sync_i (
    .clk (clk),
    .rst (rst),
    .d   (want),
    .q   (want_sync)
  );

  // gate moves on the falling edge so it changes only while clk is low
  always_ff @(negedge clk) begin
    if (rst) gate_on <= RST_ON;
    else     gate_on <= want_sync;
  end

endmodule

// File: rtl/sysclk_div2.sv
module sysclk_div2 (
  input  logic clk,
  input  logic rst,
  output logic half_o
);

  always_ff @(posedge clk) begin
    if (rst) half_o <= 1'b0;
    else     half_o <= ~half_o;
  end

endmodule

// File: rtl/sysclk_selector.sv
module sysclk_selector #(
  parameter int unsigned SYNC_STAGES = sysclk_sel_pkg::SYNC_STAGES_DEF
) (
  input  logic osc_clk,
  input  logic pll_clk,
  input  logic rst,
  input  logic pll_sel_i,
  input  logic scm_i,
  input  logic pll_on_req_i,
  output logic core_clk_o,
  output logic bus_clk_o,
  output logic pll_en_o,
  output logic busy_o
);

  import sysclk_sel_pkg::*;

  logic want_pll;
  logic tgt_q;
  logic osc_gate;
  logic pll_gate;
  logic pll_on_osc;
  logic osc_done;
  logic pll_en_q;
  logic osc_want;
  logic pll_want;
  logic sys_clk;

  // self-clock mode overrides the select bit
  assign want_pll = pll_sel_i | scm_i;

  // loop gate state seen from the oscillator domain
  sysclk_bit_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b0)
  ) pll_mirror_i (
    .clk (osc_clk),
    .rst (rst),
    .d   (pll_gate),
    .q   (pll_on_osc)
  );

  // a new target is taken only once the previous switch is seen complete
  assign osc_done = src_settled(tgt_q, osc_gate, pll_on_osc);

  always_ff @(posedge osc_clk) begin
    if (rst) begin
      tgt_q    <= 1'b0;
      pll_en_q <= 1'b0;
    end else begin
      if (osc_done) tgt_q <= want_pll;
      pll_en_q <= pll_on_req_i | want_pll | tgt_q | pll_on_osc;
    end
  end

  // break before make: each side opens only after the other has closed
  assign osc_want = ~tgt_q & ~pll_gate;
  assign pll_want =  tgt_q & ~osc_gate;

  sysclk_gate_leg #(
    .STAGES (SYNC_STAGES),
    .RST_ON (1'b1)
  ) osc_leg_i (
    .clk     (osc_clk),
    .rst     (rst),
    .want    (osc_want),
    .gate_on (osc_gate)
  );

  sysclk_gate_leg #(
    .STAGES (SYNC_STAGES),
    .RST_ON (1'b0)
  ) pll_leg_i (
    .clk     (pll_clk),
    .rst     (rst),
    .want    (pll_want),
    .gate_on (pll_gate)
  );

  assign sys_clk = (osc_clk & osc_gate) | (pll_clk & pll_gate);

  sysclk_div2 bus_div_i (
    .clk    (sys_clk),
    .rst    (rst),
    .half_o (bus_clk_o)
  );

  assign core_clk_o = sys_clk;
  assign pll_en_o   = pll_en_q;
  assign busy_o     = (want_pll != tgt_q) | ~src_settled(tgt_q, osc_gate, pll_gate);

endmodule

// File: rtl/sysclk_selector_chk.sv
module sysclk_selector_chk (
  input logic osc_clk,
  input logic pll_clk,
  input logic rst,
  input logic pll_sel_i,
  input logic scm_i,
  input logic core_clk_o,
  input logic bus_clk_o,
  input logic pll_en_o,
  input logic busy_o,
  input logic osc_gate,
  input logic pll_gate,
  input logic tgt_q
);

  // R2
  gates_excl_osc_chk: assert property (@(posedge osc_clk) disable iff (rst)
    !(osc_gate && pll_gate));

  // R2
  gates_excl_pll_chk: assert property (@(posedge pll_clk) disable iff (rst)
    !(osc_gate && pll_gate));

  // R4
  frozen_busy_chk: assert property (@(posedge osc_clk) disable iff (rst)
    (!osc_gate && !pll_gate) |-> busy_o);

  // R7
  pll_kept_on_chk: assert property (@(posedge pll_clk) disable iff (rst)
    pll_gate |-> pll_en_o);

  // R5
  tgt_rise_req_chk: assert property (@(posedge osc_clk) disable iff (rst)
    $rose(tgt_q) |-> $past(pll_sel_i || scm_i));

  // R5
  tgt_fall_req_chk: assert property (@(posedge osc_clk) disable iff (rst)
    $fell(tgt_q) |-> $past(!pll_sel_i && !scm_i));

  // R6
  bus_toggle_chk: assert property (@(posedge core_clk_o) disable iff (rst)
    1'b1 |=> (bus_clk_o != $past(bus_clk_o)));

endmodule

bind sysclk_selector sysclk_selector_chk chk_i (
  .osc_clk    (osc_clk),
  .pll_clk    (pll_clk),
  .rst        (rst),
  .pll_sel_i  (pll_sel_i),
  .scm_i      (scm_i),
  .core_clk_o (core_clk_o),
  .bus_clk_o  (bus_clk_o),
  .pll_en_o   (pll_en_o),
  .busy_o     (busy_o),
  .osc_gate   (osc_gate),
  .pll_gate   (pll_gate),
  .tgt_q      (tgt_q)
);

// File: tb/sysclk_selector_tb_top.sv
module sysclk_selector_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam real OSC_HALF = 4.0;   // 125 MHz
  localparam real PLL_HALF = 3.1;
  localparam real OSC_P    = 2.0 * OSC_HALF;
  localparam real PLL_P    = 2.0 * PLL_HALF;
  localparam real MIN_PH   = PLL_HALF - 0.05;
  localparam real BOUND    = 4.0 * OSC_P + 4.0 * PLL_P;
  localparam real TOL      = 0.05;

  logic osc_clk = 1'b0;
  logic pll_clk = 1'b0;
  logic rst = 1'b1;
  logic pll_sel = 1'b0;
  logic scm = 1'b0;
  logic pll_on_req = 1'b0;
  logic core_clk, bus_clk, pll_en, busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(OSC_HALF) osc_clk = ~osc_clk;
  always #(PLL_HALF) pll_clk = ~pll_clk;

  sysclk_selector dut_i (
    .osc_clk      (osc_clk),
    .pll_clk      (pll_clk),
    .rst          (rst),
    .pll_sel_i    (pll_sel),
    .scm_i        (scm),
    .pll_on_req_i (pll_on_req),
    .core_clk_o   (core_clk),
    .bus_clk_o    (bus_clk),
    .pll_en_o     (pll_en),
    .busy_o       (busy)
  );

  // phase-width monitor
  bit  mon_en = 1'b0;
  bit  c_seen = 1'b0;
  bit  b_seen = 1'b0;
  real last_c = 0.0;
  real last_b = 0.0;
  real max_ph = 0.0;
  int  short_ph = 0;
  int  busy_falls = 0;

  always @(core_clk) begin
    if (mon_en) begin
      if (c_seen) begin
        if ($realtime - last_c < MIN_PH) short_ph++;
        if ($realtime - last_c > max_ph) max_ph = $realtime - last_c;
      end
      c_seen = 1'b1;
      last_c = $realtime;
    end
  end

  always @(bus_clk) begin
    if (mon_en) begin
      if (b_seen && ($realtime - last_b < MIN_PH)) short_ph++;
      b_seen = 1'b1;
      last_b = $realtime;
    end
  end

  always @(negedge busy) begin
    if (mon_en) busy_falls++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0.2f expected=%0.2f", req, what, act, exp);
    end
  endtask

  task automatic measure(output real core_p, output real bus_p);
    real t1;
    @(posedge core_clk); t1 = $realtime;
    @(posedge core_clk); core_p = $realtime - t1;
    @(posedge bus_clk);  t1 = $realtime;
    @(posedge bus_clk);  bus_p = $realtime - t1;
  endtask

  task automatic wait_idle(input real t0, input real lim, output real dur);
    while (busy !== 1'b0 && ($realtime - t0) < lim) #0.1;
    dur = $realtime - t0;
  endtask

  // R8: reset state, then oscillator period
  task automatic t_reset;
    real cp, bp;
    repeat (3) @(negedge osc_clk);
    check(bus_clk === 1'b0, "R8", "bus clock low in reset", bus_clk, 0);
    check(pll_en === 1'b0, "R8", "pll enable low in reset", pll_en, 0);
    rst = 1'b0;
    repeat (4) @(negedge osc_clk);
    mon_en = 1'b1;
    check(busy === 1'b0, "R8", "busy low after reset", busy, 0);
    check(pll_en === 1'b0, "R8", "pll enable low after reset", pll_en, 0);
    measure(cp, bp);
    check(cp > OSC_P - TOL && cp < OSC_P + TOL, "R8", "core period after reset", cp, OSC_P);
  endtask

  // one source change with its timing checks
  task automatic t_switch(input bit sel, input bit scm_v, input real exp_p, input string tag);
    real t0, dur, cp, bp;
    @(negedge osc_clk); #1;
    max_ph = 0.0;
    pll_sel = sel;
    scm = scm_v;
    t0 = $realtime;
    #0.5;
    check(busy === 1'b1, "R4", "busy right after request change", busy, 1);
    wait_idle(t0, 4.0 * BOUND, dur);
    check(dur <= BOUND, "R3", "switch duration ns", dur, BOUND);
    measure(cp, bp);
    check(max_ph > OSC_P, "R4", "frozen phase during switch ns", max_ph, OSC_P);
    check(cp > exp_p - TOL && cp < exp_p + TOL, tag, "core period", cp, exp_p);
    check(bp > 2.0 * exp_p - TOL && bp < 2.0 * exp_p + TOL, "R6", "bus period", bp, 2.0 * exp_p);
  endtask

  // R7: off request ignored while loop clock is selected
  task automatic t_pll_hold;
    pll_on_req = 1'b0;
    t_switch(1'b1, 1'b0, PLL_P, "R1");
    repeat (4) @(negedge osc_clk);
    check(pll_en === 1'b1, "R7", "pll enable with off request while selected", pll_en, 1);
    t_switch(1'b0, 1'b0, OSC_P, "R1");
    repeat (6) @(negedge osc_clk);
    check(pll_en === 1'b0, "R7", "pll enable off on oscillator", pll_en, 0);
    pll_on_req = 1'b1;
    repeat (2) @(negedge osc_clk);
    check(pll_en === 1'b1, "R7", "pll enable follows request", pll_en, 1);
    pll_on_req = 1'b0;
    repeat (2) @(negedge osc_clk);
    check(pll_en === 1'b0, "R7", "pll enable drops with request", pll_en, 0);
  endtask

  // R5: self-clock mode forces the loop clock
  task automatic t_scm;
    t_switch(1'b0, 1'b1, PLL_P, "R5");
    repeat (4) @(negedge osc_clk);
    check(pll_en === 1'b1, "R5", "pll enable under self-clock mode", pll_en, 1);
    t_switch(1'b0, 1'b0, OSC_P, "R5");
  endtask

  // R9: request that flips back during a switch
  task automatic t_deferred;
    real t0, dur, cp, bp;
    int f0;
    @(negedge osc_clk); #1;
    f0 = busy_falls;
    pll_sel = 1'b1;
    t0 = $realtime;
    repeat (2) @(posedge osc_clk);
    #1;
    pll_sel = 1'b0;
    wait_idle(t0, 4.0 * BOUND, dur);
    check(dur <= 2.0 * BOUND + 2.0 * OSC_P, "R9", "deferred pair duration ns", dur, 2.0 * BOUND);
    measure(cp, bp);
    check(busy_falls - f0 == 1, "R9", "busy low pulses during pair", busy_falls - f0, 1);
    check(cp > OSC_P - TOL && cp < OSC_P + TOL, "R9", "core period after pair", cp, OSC_P);
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pll_hold();
    t_scm();
    t_deferred();
    t_switch(1'b1, 1'b0, PLL_P, "R1");
    t_switch(1'b0, 1'b0, OSC_P, "R1");
    check(short_ph == 0, "R2", "short phases seen", short_ph, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule